// File: doc/BRIEF.md
# Serial Audio Input Frame Resynchronizer

This block receives a three-wire serial audio stream (word select, bit clock, serial data) and re-times its stereo sample pairs onto the chip's own output frame. All three input lines are sampled by the system clock through a short synchronizer, so the bit clock must be several times slower than the system clock. A 16-bit left word and a 16-bit right word are shifted in MSB first. A frame starts at each falling edge of word select. Complete frames cross a small FIFO. One frame is read on every pulse of the local frame strobe.

After reset the block aligns to the first falling edge of word select. It learns the input frame period in system clocks and then watches it. A sustained change of period marks the stream as out of lock. In strict mode the outputs then go silent until software performs a resynchronization handshake with three control pins. A request pin must be held through at least one whole input frame and then released, and it counts only while a qualifier pin is high and the tolerant pin is low. In tolerant mode the block keeps playing through a lost lock. It absorbs rate mismatch by repeating the last output pair when the FIFO is empty and by discarding arriving frames when the FIFO is full. Two saturating counters report how often each of these happens.

Top module: `sai_frame_resync`

## Requirements
- R1: After reset `locked` is 0 and stays 0 until the first falling edge of `ws_in`. From that edge on, `locked` is 1.
- R2: After each falling edge of `ws_in`, the first 16 data bits (sampled on rising `bck_in`, MSB first) form the left word and the next 16 form the right word. At a steady input rate equal to the local frame rate, the pairs appear on `out_left`/`out_right` in arrival order, one pair per `frame_tick`.
- R3: The reference period is the first full input frame after alignment, counted in system clocks. `locked` falls only when two consecutive input periods each differ from the reference by more than 2 clocks. A single deviating period, or any number of deviations of 2 clocks or less, keeps `locked` at 1.
- R4: Once lock is lost it never returns by itself. `locked` is 0 while a resync request is held. A request held across at least two falling edges of `ws_in` and then released makes `locked` rise at the next falling edge. After that, frames flow in order again. A request released after fewer edges leaves the block unlocked.
- R5: A resync request made while `resync_qual` is 0 has no effect.
- R6: A resync request made while `tolerant` is 1 has no effect.
- R7: With `tolerant` at 0 and `locked` at 0, every `frame_tick` drives both output words to zero.
- R8: With `tolerant` at 1, samples keep flowing while unlocked. When the input is slower than the local frame and the FIFO is empty at a `frame_tick`, the previous pair is repeated and `hold_cnt` increments.
- R9: When a frame arrives while the 4-entry FIFO is full and no read happens in the same cycle, the frame is dropped and `skip_cnt` increments.
- R10: While reset is applied and right after it, both output words and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the oversampling clock for the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ws_in | input | 1 | Serial word select; low carries the left word, high the right word |
| bck_in | input | 1 | Serial bit clock; data sampled on its rising edge |
| sd_in | input | 1 | Serial data, MSB first |
| frame_tick | input | 1 | One-cycle local output frame strobe |
| resync_req | input | 1 | Software resynchronization request |
| resync_qual | input | 1 | Qualifier that must be 1 for a request to count |
| tolerant | input | 1 | 1 keeps playing through a lost lock using hold and skip |
| out_left | output | 16 | Left output sample, updated one cycle after `frame_tick` |
| out_right | output | 16 | Right output sample, updated one cycle after `frame_tick` |
| locked | output | 1 | Lock status of the input framing |
| hold_cnt | output | 16 | Saturating count of repeated output pairs |
| skip_cnt | output | 16 | Saturating count of dropped input frames |

## Verification
If the period monitor keeps a wrong reference or a wrong miss count, `locked` drops two input frames after a harmless drift, or stays high after a real rate change. The bench reads `locked` one frame after each deliberate change. If a FIFO pointer or the occupancy is corrupted, the output sequence shows repeated, missing or reordered pairs at the very next `frame_tick`. The bench matches the whole run against its vector table. Faults in the resync gating show as `locked` returning, or failing to return, one frame after a release.

// File: rtl/sai_rsync_pkg.sv
package sai_rsync_pkg;

  // Lock tracking states of the input framing
  typedef enum logic [2:0] {
    LK_ACQ   = 3'd0,  // waiting for a word-select falling edge
    LK_LEARN = 3'd1,  // aligned, measuring the reference period
    LK_LOCK  = 3'd2,  // aligned and period-checked
    LK_LOST  = 3'd3,  // framing kept, lock declared lost
    LK_RSYN  = 3'd4   // software resynchronization held
  } lk_state_e;

endpackage

// File: rtl/sai_rx_deser.sv
module sai_rx_deser #(
  parameter int SW     = 16,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ws_in,
  input  logic            bck_in,
  input  logic            sd_in,
  output logic            ws_fall,
  output logic [2*SW-1:0] frame_word
);

  localparam int FW = 2 * SW;

  logic [SYNC_N-1:0] ws_sy_q, bck_sy_q, sd_sy_q;
  logic              ws_dly_q, bck_dly_q;
  logic              ws_now, bck_now, sd_now;
  logic              bck_rise, ws_drop;
  logic [FW-1:0]     sh_q, sh_d, word_q;
  logic              fall_q;

  always_comb begin
    ws_now   = ws_sy_q[SYNC_N-1];
    bck_now  = bck_sy_q[SYNC_N-1];
    sd_now   = sd_sy_q[SYNC_N-1];
    bck_rise = bck_now & ~bck_dly_q;
    ws_drop  = ws_dly_q & ~ws_now;
    sh_d     = {sh_q[FW-2:0], sd_now};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_sy_q   <= '0;
      bck_sy_q  <= '0;
      sd_sy_q   <= '0;
      ws_dly_q  <= 1'b0;
      bck_dly_q <= 1'b0;
      sh_q      <= '0;
      word_q    <= '0;
      fall_q    <= 1'b0;
    end else begin
      ws_sy_q   <= {ws_sy_q[SYNC_N-2:0], ws_in};
      bck_sy_q  <= {bck_sy_q[SYNC_N-2:0], bck_in};
      sd_sy_q   <= {sd_sy_q[SYNC_N-2:0], sd_in};
      ws_dly_q  <= ws_now;
      bck_dly_q <= bck_now;
      fall_q    <= ws_drop;
      if (bck_rise) sh_q   <= sh_d;
      if (ws_drop)  word_q <= sh_q;
    end
  end

  assign ws_fall    = fall_q;
  assign frame_word = word_q;

  // R2: a frame boundary is a single-cycle event
  a_r2_single_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |=> !fall_q);

endmodule

// File: rtl/sai_lock_mon.sv
module sai_lock_mon
  import sai_rsync_pkg::*;
#(
  parameter int PW  = 12,
  parameter int TOL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_fall,
  input  logic resync_req,
  input  logic resync_qual,
  input  logic tolerant,
  output logic locked,
  output logic aligned
);

  localparam logic [1:0] RS_DONE = 2'd2;

  lk_state_e     st_q, st_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] ref_q, ref_d;
  logic [PW-1:0] dev;
  logic          miss_q, miss_d;
  logic [1:0]    rsf_q, rsf_d;
  logic          rs_on, off_rate;

  always_comb begin
    rs_on    = resync_req & resync_qual & ~tolerant;
    dev      = (pcnt_q > ref_q) ? (pcnt_q - ref_q) : (ref_q - pcnt_q);
    off_rate = dev > PW'(TOL);

    if (ws_fall)               pcnt_d = PW'(1);
    else if (pcnt_q != '1)     pcnt_d = pcnt_q + PW'(1);
    else                       pcnt_d = pcnt_q;

    st_d   = st_q;
    ref_d  = ref_q;
    miss_d = miss_q;
    rsf_d  = rsf_q;

    if (rs_on && st_q != LK_RSYN) begin
      st_d  = LK_RSYN;
      rsf_d = '0;
    end else begin
      case (st_q)
        LK_ACQ:   if (ws_fall) st_d = LK_LEARN;
        LK_LEARN: if (ws_fall) begin
                    ref_d  = pcnt_q;
                    miss_d = 1'b0;
                    st_d   = LK_LOCK;
                  end
        LK_LOCK:  if (ws_fall) begin
                    if (off_rate) begin
                      if (miss_q) st_d = LK_LOST;
                      else        miss_d = 1'b1;
                    end else begin
                      miss_d = 1'b0;
                    end
                  end
        LK_LOST:  st_d = LK_LOST;
        LK_RSYN:  begin
                    if (!rs_on)
                      st_d = (rsf_q == RS_DONE) ? LK_ACQ : LK_LOST;
                    else if (ws_fall && rsf_q != RS_DONE)
                      rsf_d = rsf_q + 2'd1;
                  end
        default:  st_d = LK_ACQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_ACQ;
      pcnt_q <= '0;
      ref_q  <= '0;
      miss_q <= 1'b0;
      rsf_q  <= '0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      ref_q  <= ref_d;
      miss_q <= miss_d;
      rsf_q  <= rsf_d;
    end
  end

  assign locked  = (st_q == LK_LEARN) || (st_q == LK_LOCK);
  assign aligned = locked || (st_q == LK_LOST);

  // R1: leaving acquisition needs a word-select falling edge
  a_r1_lock_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == LK_ACQ && st_q == LK_LEARN) |-> $past(ws_fall));

  // R3: lock is dropped only after an earlier recorded miss
  a_r3_two_misses: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == LK_LOCK && st_q == LK_LOST) |-> $past(miss_q));

  // R4: a lost lock is left only through a resync hold
  a_r4_no_self_recover: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == LK_LOST && st_q != LK_LOST) |-> st_q == LK_RSYN);

  // R5, R6: a resync hold starts only from a qualified, non-tolerant request
  a_r5_r6_gated_request: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_RSYN && $past(st_q) != LK_RSYN) |->
      ($past(resync_req) && $past(resync_qual) && !$past(tolerant)));

endmodule

// File: rtl/sai_frame_fifo.sv
module sai_frame_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             wr_ok, rd_ok;
  logic [DEPTH-1:0] wr_sel;

  always_comb begin
    empty = (cnt_q == '0);
    full  = (cnt_q == CW'(DEPTH));
    wr_ok = push & (~full | pop) & ~flush;
    rd_ok = pop & ~empty & ~flush;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (rd_ok) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign wr_sel[g] = wr_ok && (wp_q == AW'(g));
    always_ff @(posedge clk) begin
      if (wr_sel[g]) mem[g] <= wdata;
    end
  end

  assign rdata = mem[rp_q];

  // R9: occupancy never exceeds the depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R9: an arrival into a full FIFO without a read leaves occupancy unchanged
  a_r9_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/sai_frame_resync.sv
module sai_frame_resync #(
  parameter int SW     = 16,
  parameter int PW     = 12,
  parameter int TOL    = 2,
  parameter int FDEPTH = 4,
  parameter int CNTW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ws_in,
  input  logic            bck_in,
  input  logic            sd_in,
  input  logic            frame_tick,
  input  logic            resync_req,
  input  logic            resync_qual,
  input  logic            tolerant,
  output logic [SW-1:0]   out_left,
  output logic [SW-1:0]   out_right,
  output logic            locked,
  output logic [CNTW-1:0] hold_cnt,
  output logic [CNTW-1:0] skip_cnt
);

  localparam int FW = 2 * SW;

  logic            rst_meta_q, rst_sn;
  logic            ws_fall, aligned, lk;
  logic [FW-1:0]   frame_word, head;
  logic            f_empty, f_full, f_push, f_pop, f_flush, play;
  logic [FW-1:0]   out_q, out_d;
  logic [CNTW-1:0] hold_q, hold_d, skip_q, skip_d;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  sai_rx_deser #(.SW(SW), .SYNC_N(2)) u_deser (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ws_in      (ws_in),
    .bck_in     (bck_in),
    .sd_in      (sd_in),
    .ws_fall    (ws_fall),
    .frame_word (frame_word)
  );

  sai_lock_mon #(.PW(PW), .TOL(TOL)) u_lock (
    .clk         (clk),
    .rst_n       (rst_sn),
    .ws_fall     (ws_fall),
    .resync_req  (resync_req),
    .resync_qual (resync_qual),
    .tolerant    (tolerant),
    .locked      (lk),
    .aligned     (aligned)
  );

  sai_frame_fifo #(.DW(FW), .DEPTH(FDEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sn),
    .flush (f_flush),
    .push  (f_push),
    .pop   (f_pop),
    .wdata (frame_word),
    .rdata (head),
    .empty (f_empty),
    .full  (f_full)
  );

  always_comb begin
    play    = lk | tolerant;
    f_flush = ~aligned;
    f_push  = ws_fall & aligned & play;
    f_pop   = frame_tick & play & ~f_empty;

    out_d  = out_q;
    hold_d = hold_q;
    skip_d = skip_q;
    if (frame_tick) begin
      if (!play) begin
        out_d = '0;
      end else if (f_empty) begin
        if (hold_q != '1) hold_d = hold_q + CNTW'(1);
      end else begin
        out_d = head;
      end
    end
    if (f_push && f_full && !f_pop && skip_q != '1)
      skip_d = skip_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_q  <= '0;
      hold_q <= '0;
      skip_q <= '0;
    end else begin
      if (frame_tick) out_q <= out_d;
      hold_q <= hold_d;
      skip_q <= skip_d;
    end
  end

  assign out_left  = out_q[FW-1:SW];
  assign out_right = out_q[SW-1:0];
  assign locked    = lk;
  assign hold_cnt  = hold_q;
  assign skip_cnt  = skip_q;

  // R7: strict mode silences the output while unlocked
  a_r7_silent_unlocked: assert property (@(posedge clk) disable iff (!rst_sn)
    (frame_tick && !lk && !tolerant) |=> (out_left == '0 && out_right == '0));

  // R8: an empty FIFO at a strobe repeats the previous pair
  a_r8_hold_repeats: assert property (@(posedge clk) disable iff (!rst_sn)
    (frame_tick && play && f_empty) |=> ($stable(out_left) && $stable(out_right)));

  // R8: the hold counter only moves on a strobe
  a_r8_hold_on_tick: assert property (@(posedge clk) disable iff (!rst_sn)
    (hold_cnt != $past(hold_cnt)) |-> $past(frame_tick));

endmodule

// File: tb/tb_sai_frame_resync.sv
`timescale 1ns/1ps
module tb_sai_frame_resync;

  localparam int NV    = 8;
  localparam int LOC_P = 256;
  localparam int WD    = 150000;
  localparam logic [31:0] VEC [NV] = '{
    32'hA5C3_1234, 32'h8001_7FFE, 32'h0F0F_F0F0, 32'h1357_9BDF,
    32'hFFFF_0001, 32'h2468_ACE0, 32'h7A7A_8585, 32'hC001_D00D
  };

  logic        clk = 1'b0;
  logic        rst_n, ws_in, bck_in, sd_in, frame_tick;
  logic        resync_req, resync_qual, tolerant;
  logic [15:0] out_left, out_right, hold_cnt, skip_cnt;
  logic        locked;

  int checks = 0;
  int fails  = 0;
  int lcnt   = 0;
  int log_n  = 0;
  logic [31:0] logv [512];

  always #2 clk = ~clk;

  sai_frame_resync dut (
    .clk(clk), .rst_n(rst_n), .ws_in(ws_in), .bck_in(bck_in), .sd_in(sd_in),
    .frame_tick(frame_tick), .resync_req(resync_req), .resync_qual(resync_qual),
    .tolerant(tolerant), .out_left(out_left), .out_right(out_right),
    .locked(locked), .hold_cnt(hold_cnt), .skip_cnt(skip_cnt)
  );

  // local frame strobe plus a log of the pair seen after each strobe
  initial frame_tick = 1'b0;
  always @(negedge clk) begin
    if (frame_tick && log_n < 512) begin
      logv[log_n] = {out_left, out_right};
      log_n = log_n + 1;
    end
    frame_tick = (lcnt == LOC_P - 1);
    lcnt = (lcnt == LOC_P - 1) ? 0 : lcnt + 1;
  end

  initial begin
    repeat (WD) @(posedge clk);
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [31:0] w, input int h, input int extra);
    for (int i = 0; i < 32; i++) begin
      ws_in  = (i >= 16);
      sd_in  = w[31 - i];
      bck_in = 1'b0;
      repeat (h) @(negedge clk);
      bck_in = 1'b1;
      repeat (h) @(negedge clk);
    end
    repeat (extra) @(negedge clk);
  endtask

  task automatic check_seq(input int mark, input string tag);
    int base;
    int idx;
    logic [31:0] got;
    base = -1;
    for (int k = mark; k < log_n; k++)
      if (base < 0 && logv[k] == VEC[0]) base = k;
    chk(base >= 0, tag, 32'h0, VEC[0]);
    for (int k = 1; k < NV; k++) begin
      idx = base + k;
      got = (base >= 0 && idx < log_n) ? logv[idx] : 32'h0;
      chk(got == VEC[k], tag, got, VEC[k]);
    end
  endtask

  initial begin
    int mark;
    int h0, s0;
    rst_n = 1'b0; ws_in = 1'b1; bck_in = 1'b0; sd_in = 1'b0;
    resync_req = 1'b0; resync_qual = 1'b0; tolerant = 1'b0;
    repeat (10) @(negedge clk);
    chk(out_left == 0 && out_right == 0, "R10 outputs in reset", {out_left, out_right}, 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk(hold_cnt == 0 && skip_cnt == 0, "R10 counters after reset", {hold_cnt, skip_cnt}, 0);
    chk(out_left == 0 && out_right == 0, "R10 outputs after reset", {out_left, out_right}, 0);
    chk(locked == 1'b0, "R1 unlocked before first fall", 32'(locked), 0);

    // R2: table walk at the nominal rate; the first fall aligns (R1)
    mark = log_n;
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v], 4, 0);
      if (v == 0) chk(locked == 1'b1, "R1 locked after first fall", 32'(locked), 1);
    end
    for (int f = 0; f < 3; f++) send_frame(32'h0, 4, 0);
    check_seq(mark, "R2 ordered pairs");

    // R3: deviations within tolerance, and one isolated large deviation
    for (int f = 0; f < 3; f++) send_frame(32'h1111_2222, 4, 2);
    send_frame(32'h1111_2222, 4, 0);
    chk(locked == 1'b1, "R3 drift of 2 clocks kept", 32'(locked), 1);
    send_frame(32'h1111_2222, 4, 40);
    send_frame(32'h1111_2222, 4, 0);
    send_frame(32'h1111_2222, 4, 0);
    chk(locked == 1'b1, "R3 single deviation kept", 32'(locked), 1);

    // R3: two consecutive slow periods lose lock
    send_frame(32'h3333_4444, 5, 0);
    send_frame(32'h3333_4444, 5, 0);
    chk(locked == 1'b1, "R3 one slow period kept", 32'(locked), 1);
    send_frame(32'h3333_4444, 5, 0);
    chk(locked == 1'b0, "R3 lost after two slow periods", 32'(locked), 0);

    // R7: silent output while unlocked in strict mode
    send_frame(32'h5555_6666, 4, 0);
    chk(out_left == 0 && out_right == 0, "R7 zero output", {out_left, out_right}, 0);

    // R4: no recovery at the nominal rate without software
    send_frame(32'h5555_6666, 4, 0);
    send_frame(32'h5555_6666, 4, 0);
    chk(locked == 1'b0, "R4 no self recovery", 32'(locked), 0);

    // R5: request without qualifier ignored
    resync_qual = 1'b0; resync_req = 1'b1;
    for (int f = 0; f < 3; f++) send_frame(32'h5555_6666, 4, 0);
    resync_req = 1'b0;
    send_frame(32'h5555_6666, 4, 0);
    send_frame(32'h5555_6666, 4, 0);
    chk(locked == 1'b0, "R5 unqualified request ignored", 32'(locked), 0);

    // R6: request in tolerant mode ignored
    resync_qual = 1'b1; tolerant = 1'b1; resync_req = 1'b1;
    for (int f = 0; f < 3; f++) send_frame(32'h5555_6666, 4, 0);
    resync_req = 1'b0;
    tolerant = 1'b0;
    send_frame(32'h5555_6666, 4, 0);
    send_frame(32'h5555_6666, 4, 0);
    chk(locked == 1'b0, "R6 tolerant request ignored", 32'(locked), 0);

    // R4: request shorter than one full frame
    resync_req = 1'b1;
    send_frame(32'h5555_6666, 4, 0);
    resync_req = 1'b0;
    send_frame(32'h5555_6666, 4, 0);
    send_frame(32'h5555_6666, 4, 0);
    chk(locked == 1'b0, "R4 short request ignored", 32'(locked), 0);

    // R4: full request, release, relock at the next fall
    resync_req = 1'b1;
    send_frame(32'h5555_6666, 4, 0);
    chk(locked == 1'b0, "R4 unlocked while held", 32'(locked), 0);
    send_frame(32'h5555_6666, 4, 0);
    send_frame(32'h5555_6666, 4, 0);
    resync_req = 1'b0;
    send_frame(32'h0, 4, 0);
    chk(locked == 1'b1, "R4 relocked after release", 32'(locked), 1);
    mark = log_n;
    for (int v = 0; v < NV; v++) send_frame(VEC[v], 4, 0);
    for (int f = 0; f < 3; f++) send_frame(32'h0, 4, 0);
    check_seq(mark, "R4 ordered pairs after relock");

    // R8: tolerant mode, slow input
    tolerant = 1'b1;
    h0 = int'(hold_cnt); s0 = int'(skip_cnt);
    for (int f = 0; f < 12; f++) send_frame(VEC[f % NV], 6, 0);
    chk(locked == 1'b0, "R8 lock lost on slow input", 32'(locked), 0);
    chk(int'(hold_cnt) - h0 >= 3, "R8 holds on slow input", 32'(int'(hold_cnt) - h0), 3);
    chk(int'(skip_cnt) == s0, "R8 no skips on slow input", 32'(skip_cnt), 32'(s0));
    chk({out_left, out_right} != 32'h0, "R8 output keeps playing", {out_left, out_right}, 32'h1);

    // R9: tolerant mode, fast input
    h0 = int'(hold_cnt); s0 = int'(skip_cnt);
    for (int f = 0; f < 24; f++) send_frame(VEC[f % NV], 2, 0);
    chk(int'(skip_cnt) - s0 >= 4, "R9 skips on fast input", 32'(int'(skip_cnt) - s0), 4);
    chk(int'(hold_cnt) - h0 <= 1, "R9 few holds on fast input", 32'(int'(hold_cnt) - h0), 1);
    chk({out_left, out_right} != 32'h0, "R9 output keeps playing", {out_left, out_right}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule